// File: doc/BRIEF.md
# Synchronous-Termination Memory Responder

This block is the memory side of a 32-bit processor bus on which the slave closes every transfer by pulsing a termination signal sampled on the rising clock edge. It holds a small word-organised register-file memory. It answers reads and byte-lane writes after a fixed number of wait states. When the accessed address lies in a non-cacheable window, it raises a cache-inhibit flag together with the termination pulse.

The processor marks a cycle with the address strobe and gives the direction, a two-bit transfer size, a function code, the byte address and the write data. The responder counts the configured wait states from the first rising edge that samples the strobe. It then asserts termination for exactly one clock and drives read data with an output enable. The data strobe is not used: a two-clock write never asserts it, so write data is taken on the clock edge that ends the termination cycle. A write is committed only if the address strobe is still asserted at that edge. A transfer the processor cancels before that point leaves the memory untouched.

Top module: `stm_responder`

## Requirements
- R1: While reset is held and after its release, termOut, inhibitOut and dataOe are 0 and rdData is 0.
- R2: If busStrobe is first sampled high at rising edge k, termOut is high for the clock cycle that follows edge k+WAIT_STATES (default WAIT_STATES = 1).
- R3: termOut is high for exactly one clock per transfer.
- R4: For a read (readNotWrite = 1), rdData carries the addressed word and dataOe is 1 during the termination cycle and the cycle after it. In the cycle after that, dataOe is 0 and rdData is 0.
- R5: A write (readNotWrite = 0) is captured on the rising edge that ends the termination cycle, whatever the level of dataStrobe. dataOe stays 0 throughout a write.
- R6: A write is committed only if busStrobe is high at that capturing edge. If busStrobe drops before termination, no termination is given and the memory word keeps its value.
- R7: sizeCode selects 1, 2, 3 or 4 bytes for codes 01, 10, 11 and 00. The bytes start at lane addr[1:0], where lane n is wrData[8n+7:8n]. Lanes past lane 3 are dropped, and only the selected lanes of word addr[5:2] change.
- R8: inhibitOut is high only in the termination cycle, and only when NC_LO <= addr <= NC_HI (default 0x20 to 0x3F).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| busStrobe | input | 1 | Address strobe, high while a transfer is in progress |
| dataStrobe | input | 1 | Data strobe, accepted and ignored |
| readNotWrite | input | 1 | 1 = read, 0 = write |
| sizeCode | input | 2 | Transfer size: 01/10/11/00 = 1/2/3/4 bytes |
| funcCode | input | 3 | Function code, accepted without effect |
| addr | input | ADDR_W (8) | Byte address |
| wrData | input | 32 | Write data on its byte lanes |
| termOut | output | 1 | Synchronous termination pulse |
| inhibitOut | output | 1 | Cache-inhibit, valid with termOut |
| rdData | output | 32 | Read data, zero when not driven |
| dataOe | output | 1 | Read data output enable |

## Verification
The assertions assume that the master keeps busStrobe high through the edge that samples termination. They also assume that it then drops busStrobe for at least one rising edge before the next transfer starts, so the strobe-run counter in the checker starts at zero for each transfer. The bench drives every input on the falling edge and holds address, size and direction steady for the whole transfer. It lowers the strobe in the cycle after termination and leaves a gap of idle edges between transfers. The one deliberate exception is the cancelled write, where the strobe falls before termination could occur.

// File: rtl/stm_pkg.sv
package stm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_TERM,
    ST_HOLD,
    ST_DRAIN
  } stmState_e;

  typedef struct packed {
    logic captureTerm;  // edge entering the termination cycle
    logic commitWrite;  // edge leaving it, strobe still high, write cycle
    logic termNow;      // termination cycle
    logic driveOut;     // read data on the bus
  } stmStrobes_t;

  // byte lanes touched by a transfer of the given size at the given offset
  function automatic logic [3:0] laneMask(input logic [1:0] sizeSel,
                                          input logic [1:0] offs);
    logic [6:0] span;
    logic [6:0] shifted;
    span    = (sizeSel == 2'b00) ? 7'h0F : ((7'h01 << sizeSel) - 7'h01);
    shifted = span << offs;
    return shifted[3:0];
  endfunction

endpackage

// File: rtl/stm_ctrl.sv
module stm_ctrl
  import stm_pkg::*;
#(
  parameter int WAIT_STATES = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busStrobe,
  input  logic        readNotWrite,
  output stmStrobes_t strobes
);

  localparam int CW = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
  localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_STATES);

  stmState_e state, nextState;
  logic [CW-1:0] waitCnt;
  logic rnwHeld;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (busStrobe) nextState = (WAIT_STATES == 0) ? ST_TERM : ST_WAIT;
      ST_WAIT:  if (!busStrobe) nextState = ST_IDLE;
                else if (waitCnt == WAIT_LAST) nextState = ST_TERM;
      ST_TERM:  nextState = ST_HOLD;
      ST_HOLD:  nextState = busStrobe ? ST_DRAIN : ST_IDLE;
      ST_DRAIN: if (!busStrobe) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      rnwHeld <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && busStrobe) begin
        rnwHeld <= readNotWrite;
        waitCnt <= CW'(1);
      end else if (state == ST_WAIT) begin
        waitCnt <= waitCnt + CW'(1);
      end
    end
  end

  always_comb begin
    strobes.captureTerm = (nextState == ST_TERM) && (state != ST_TERM);
    strobes.commitWrite = (state == ST_TERM) && busStrobe && !rnwHeld;
    strobes.termNow     = (state == ST_TERM);
    strobes.driveOut    = ((state == ST_TERM) || (state == ST_HOLD)) && rnwHeld;
  end

endmodule

// File: rtl/stm_datapath.sv
module stm_datapath
  import stm_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DEPTH_LOG2 = 4,
  parameter logic [ADDR_W-1:0] NC_LO = 8'h20,
  parameter logic [ADDR_W-1:0] NC_HI = 8'h3F
) (
  input  logic              clk,
  input  logic              rstN,
  input  stmStrobes_t       strobes,
  input  logic [1:0]        sizeCode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic              inhibitOut,
  output logic [31:0]       rdData,
  output logic              dataOe
);

  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam int LANES = 4;

  logic [31:0] mem [DEPTH];
  logic [31:0] rdReg;
  logic        inhReg;
  logic [DEPTH_LOG2-1:0] wordIdx;
  logic [3:0]  laneEn;
  logic [31:0] mergedWord;
  logic        inWindow;

  assign wordIdx  = addr[DEPTH_LOG2+1:2];
  assign laneEn   = laneMask(sizeCode, addr[1:0]);
  assign inWindow = (addr >= NC_LO) && (addr <= NC_HI);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign mergedWord[8*g +: 8] = laneEn[g] ? wrData[8*g +: 8] : mem[wordIdx][8*g +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdReg  <= '0;
      inhReg <= 1'b0;
    end else begin
      if (strobes.captureTerm) begin
        rdReg  <= mem[wordIdx];
        inhReg <= inWindow;
      end
      if (strobes.commitWrite) mem[wordIdx] <= mergedWord;
    end
  end

  assign inhibitOut = strobes.termNow & inhReg;
  assign dataOe     = strobes.driveOut;
  assign rdData     = strobes.driveOut ? rdReg : '0;

endmodule

// File: rtl/stm_responder.sv
module stm_responder
  import stm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DEPTH_LOG2  = 4,
  parameter int WAIT_STATES = 1,
  parameter logic [ADDR_W-1:0] NC_LO = 8'h20,
  parameter logic [ADDR_W-1:0] NC_HI = 8'h3F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busStrobe,
  input  logic              dataStrobe,
  input  logic              readNotWrite,
  input  logic [1:0]        sizeCode,
  input  logic [2:0]        funcCode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic              termOut,
  output logic              inhibitOut,
  output logic [31:0]       rdData,
  output logic              dataOe
);

  stmStrobes_t strobes;
  logic unusedSink;

  // data strobe and function code carry no meaning for this responder
  assign unusedSink = ^{dataStrobe, funcCode};

  stm_ctrl #(.WAIT_STATES(WAIT_STATES)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .busStrobe    (busStrobe),
    .readNotWrite (readNotWrite),
    .strobes      (strobes)
  );

  stm_datapath #(
    .ADDR_W(ADDR_W), .DEPTH_LOG2(DEPTH_LOG2), .NC_LO(NC_LO), .NC_HI(NC_HI)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .sizeCode   (sizeCode),
    .addr       (addr),
    .wrData     (wrData),
    .inhibitOut (inhibitOut),
    .rdData     (rdData),
    .dataOe     (dataOe)
  );

  assign termOut = strobes.termNow;

endmodule

// File: rtl/stm_checker.sv
module stm_checker #(
  parameter int WAIT_STATES = 1
) (
  input logic clk,
  input logic rstN,
  input logic busStrobe,
  input logic termOut,
  input logic inhibitOut,
  input logic dataOe
);

  logic [3:0] strobeRun;

  always_ff @(posedge clk) begin
    if (!rstN || !busStrobe) strobeRun <= '0;
    else if (strobeRun != 4'hF) strobeRun <= strobeRun + 4'h1;
  end

  AST_TERM_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(termOut) |-> (strobeRun == 4'(WAIT_STATES + 1))); // R2
  AST_TERM_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    termOut |=> !termOut); // R3
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    termOut |=> ##1 !dataOe); // R4
  AST_TERM_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    termOut |-> $past(busStrobe)); // R6
  AST_INHIBIT_IN_TERM: assert property (@(posedge clk) disable iff (!rstN)
    inhibitOut |-> termOut); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!termOut && !dataOe)); // R1

endmodule

bind stm_responder stm_checker #(.WAIT_STATES(WAIT_STATES)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busStrobe  (busStrobe),
  .termOut    (termOut),
  .inhibitOut (inhibitOut),
  .dataOe     (dataOe)
);

// File: tb/sim_stm_responder.sv
module sim_stm_responder;

  localparam int CLK_P = 10;
  localparam int WS    = 1;

  typedef struct packed {
    logic        rnw;
    logic [1:0]  size;
    logic [7:0]  adr;
    logic [31:0] wdat;
    logic [31:0] expRd;
    logic        expInh;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 8'h04, 32'h11223344, 32'h0, 1'b0},
    '{1'b1, 2'b00, 8'h04, 32'h0, 32'h11223344, 1'b0},
    '{1'b0, 2'b01, 8'h05, 32'h0000AA00, 32'h0, 1'b0},
    '{1'b1, 2'b00, 8'h04, 32'h0, 32'h1122AA44, 1'b0},
    '{1'b0, 2'b10, 8'h0A, 32'h55660000, 32'h0, 1'b0},
    '{1'b1, 2'b00, 8'h08, 32'h0, 32'h55660000, 1'b0},
    '{1'b0, 2'b11, 8'h0D, 32'h778899FF, 32'h0, 1'b0},
    '{1'b1, 2'b00, 8'h0C, 32'h0, 32'h77889900, 1'b0},
    '{1'b0, 2'b10, 8'h13, 32'hCCDDEEFF, 32'h0, 1'b0},
    '{1'b1, 2'b00, 8'h10, 32'h0, 32'hCC000000, 1'b0},
    '{1'b0, 2'b00, 8'h24, 32'hDEADBEEF, 32'h0, 1'b1},
    '{1'b1, 2'b00, 8'h24, 32'h0, 32'hDEADBEEF, 1'b1},
    '{1'b1, 2'b00, 8'h3C, 32'h0, 32'h0, 1'b1},
    '{1'b1, 2'b00, 8'h40, 32'h0, 32'h0, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busStrobe = 1'b0, dataStrobe = 1'b0, readNotWrite = 1'b1;
  logic [1:0] sizeCode = 2'b00;
  logic [2:0] funcCode = 3'd5;
  logic [7:0] addr = 8'h0;
  logic [31:0] wrData = 32'h0;
  logic termOut, inhibitOut, dataOe;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  stm_responder u0 (
    .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .dataStrobe(dataStrobe),
    .readNotWrite(readNotWrite), .sizeCode(sizeCode), .funcCode(funcCode),
    .addr(addr), .wrData(wrData), .termOut(termOut), .inhibitOut(inhibitOut),
    .rdData(rdData), .dataOe(dataOe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one full transfer; inputs change and outputs are sampled on falling edges
  task automatic runVec(input vec_t v, input logic dsLevel);
    int waited;
    waited = 0;
    @(negedge clk);
    busStrobe = 1'b1; dataStrobe = dsLevel; readNotWrite = v.rnw;
    sizeCode = v.size; addr = v.adr; wrData = v.wdat;
    do begin
      @(negedge clk);
      waited++;
    end while (!termOut && waited < 20);
    chk("R2", "cycles to termination", 32'(waited), 32'(WS + 1));
    chk("R8", "inhibit in termination cycle", {31'b0, inhibitOut}, {31'b0, v.expInh});
    if (v.rnw) begin
      chk("R7", "read data", rdData, v.expRd);
      chk("R4", "oe in termination cycle", {31'b0, dataOe}, 32'd1);
    end else begin
      chk("R5", "oe during write", {31'b0, dataOe}, 32'd0);
    end
    @(negedge clk);
    chk("R3", "termination released", {31'b0, termOut}, 32'd0);
    chk("R8", "inhibit after termination", {31'b0, inhibitOut}, 32'd0);
    if (v.rnw) begin
      chk("R4", "oe hold cycle", {31'b0, dataOe}, 32'd1);
      chk("R4", "data hold cycle", rdData, v.expRd);
    end
    busStrobe = 1'b0; dataStrobe = 1'b0;
    @(negedge clk);
    chk("R4", "oe released", {31'b0, dataOe}, 32'd0);
    chk("R4", "bus data released", rdData, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "term in reset", {31'b0, termOut}, 32'd0);
    chk("R1", "oe in reset", {31'b0, dataOe}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "term after reset", {31'b0, termOut}, 32'd0);
    chk("R1", "inhibit after reset", {31'b0, inhibitOut}, 32'd0);
    chk("R1", "rdData after reset", rdData, 32'h0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], 1'b0);

    // R6: write cancelled before termination must leave word 1 intact
    @(negedge clk);
    busStrobe = 1'b1; readNotWrite = 1'b0; sizeCode = 2'b00;
    addr = 8'h04; wrData = 32'hFFFFFFFF;
    @(negedge clk);
    chk("R6", "no termination yet", {31'b0, termOut}, 32'd0);
    busStrobe = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R6", "no termination after cancel", {31'b0, termOut}, 32'd0);
    end
    runVec('{1'b1, 2'b00, 8'h04, 32'h0, 32'h1122AA44, 1'b0}, 1'b0);

    // R5: data strobe level does not matter; write still lands on the clock edge
    runVec('{1'b0, 2'b00, 8'h14, 32'hA5A5A5A5, 32'h0, 1'b0}, 1'b1);
    runVec('{1'b1, 2'b00, 8'h14, 32'h0, 32'hA5A5A5A5, 1'b0}, 1'b0);

    // R7: single byte at lane 3 of a fresh word
    runVec('{1'b0, 2'b01, 8'h1B, 32'h3C000000, 32'h0, 1'b0}, 1'b0);
    runVec('{1'b1, 2'b00, 8'h18, 32'h0, 32'h3C000000, 1'b0}, 1'b0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule